// File: doc/BRIEF.md
# Receive Flow-Control and Handshake Unit

This unit sits between a serial port's bit engine and the host side of a terminal link. It holds one 8-byte queue for received bytes and one for bytes to send. It watches how full the receive queue is and throttles the far end when the queue fills. The unit runs in one of three modes. In software mode it sends in-band pause and resume characters and obeys the ones it receives. In request mode the transmit pin is reused as an active-low request-to-send line, so the unit does not transmit. In clear mode the receive pin is reused as an active-low clear-to-send input, so the unit does not receive.

The pause code is 0x13 and the resume code is 0x11. In software mode these two codes are taken out of the receive stream and change whether local data may be sent. The unit also puts its own pause and resume codes into the transmit stream, ahead of any queued data byte. The throttle changes state only when the fill level crosses a threshold: a high mark to pause and a low mark to resume. A byte is never handed to the bit engine while that engine reports busy.

Top module: `flowctl_unit`

## Requirements
- R1: After a synchronous reset, the unit is in this state: rx_count is 0, both overrun flags are 0, tx_start is 0 and rts_n is 1.
- R2: The receive queue holds up to 8 bytes. It returns them on rd_data in arrival order, and rx_count updates on the edge after a push or a pop. A byte that arrives while the queue holds 8 is dropped and sets rx_overrun, which stays set until reset. A read of an empty queue is ignored.
- R3: The transmit queue holds up to 8 bytes. A write while it holds 8 is dropped and sets tx_overrun, which stays set until reset. Queued bytes are started in write order.
- R4: With cfg_swflow set and cfg_rts_mode clear, a received 0x13 stops data bytes from starting and a received 0x11 lets them start again. Neither code is stored. With cfg_swflow clear, both codes are stored as ordinary data.
- R5: With cfg_rts_mode set, rts_n goes to 1 one edge after rx_count is at least 5. It returns to 0 one edge after rx_count is at most 1. Between those two points it holds its last value. With cfg_rts_mode clear, rts_n is 1 one edge later.
- R6: In software mode, a 0x13 is queued for sending when rx_count reaches 2, and a 0x11 is queued when rx_count falls back to 1 or below. Only one code is queued for each threshold crossing.
- R7: tx_start is a one-cycle pulse. It is raised only on the edge after a cycle in which tx_busy is 0 and tx_start is 0. A queued pause or resume code is started before any queued data byte.
- R8: With cfg_cts_mode set, received bytes are ignored, and a data byte starts only on the edge after a cycle in which cts_n is 0.
- R9: With cfg_rts_mode set, no byte is started and received bytes are still stored. If cfg_swflow is also set, request mode takes precedence: 0x11 and 0x13 are stored and no code is injected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rts_mode | input | 1 | Transmit pin reused as request line; transmit off |
| cfg_cts_mode | input | 1 | Receive pin reused as clear input; receive off |
| cfg_swflow | input | 1 | In-band pause/resume characters enabled |
| rx_valid | input | 1 | Byte from the receive bit engine is valid |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | Pop the oldest received byte |
| rd_data | output | 8 | Oldest received byte (valid while rx_count > 0) |
| rx_count | output | 4 | Receive queue fill level |
| rx_overrun | output | 1 | Sticky: a received byte was dropped |
| wr_en | input | 1 | Push a byte to send |
| wr_data | input | 8 | Byte to send |
| tx_overrun | output | 1 | Sticky: a byte to send was dropped |
| tx_busy | input | 1 | Transmit bit engine is shifting a byte |
| tx_start | output | 1 | One-cycle start strobe to the bit engine |
| tx_byte | output | 8 | Byte handed over with tx_start |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
Each result has a fixed latency:

- rx_count, rd_data and the overrun flags change on the first rising edge after the push, pop or write.
- rts_n and the queuing of a pause or resume code follow one edge after rx_count crosses a threshold.
- A data byte starts one edge after it is written, if the engine is idle.
- An injected code starts one edge after it is queued, so it appears two edges after the fill change.

The bench holds a behavioural model built from queues and flags. The model advances on the same rising edge as the unit. Every output is compared at the following falling edge, so each comparison lands in the cycle the latency above predicts. Directed checks are placed only after enough idle cycles for every latency to have elapsed.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  localparam byte_t XON_CODE  = 8'h11;
  localparam byte_t XOFF_CODE = 8'h13;
endpackage

// File: rtl/flowctl_fifo.sv
module flowctl_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          overrun
);
  localparam logic [CW-1:0] FULL_V = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, rd_ok;

  assign wr_ok   = wr_en && (count != FULL_V);
  assign rd_ok   = rd_en && (count != '0);
  assign rd_data = mem[rp];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (rd_ok) rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wr_en && !wr_ok) overrun <= 1'b1;
    end
  end

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && count == FULL_V) |=> (count == FULL_V && overrun))
    else $error("full write not dropped"); // R2 R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun)
    else $error("overrun flag cleared"); // R2 R3
endmodule

// File: rtl/flowctl_throttle.sv
module flowctl_throttle import flowctl_pkg::*; #(
  parameter int CW = 4,
  parameter int RTS_HI = 5,
  parameter int SW_HI = 2,
  parameter int RESUME_LVL = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hw_mode,
  input  logic          sw_mode,
  input  logic [CW-1:0] fill,
  input  logic          ctl_taken,
  output logic          rts_n,
  output logic          ctl_pend,
  output byte_t         ctl_char
);
  localparam logic [CW-1:0] HW_V  = CW'(RTS_HI);
  localparam logic [CW-1:0] SW_V  = CW'(SW_HI);
  localparam logic [CW-1:0] RES_V = CW'(RESUME_LVL);

  logic          flow_on, flow_nxt, active, go_off, go_on;
  logic [CW-1:0] hi_lvl;

  always_comb begin
    active = hw_mode || sw_mode;
    hi_lvl = hw_mode ? HW_V : SW_V;
    go_off = active && flow_on && (fill >= hi_lvl);
    go_on  = active && !flow_on && (fill <= RES_V);
    if (!active)     flow_nxt = 1'b1;
    else if (go_off) flow_nxt = 1'b0;
    else if (go_on)  flow_nxt = 1'b1;
    else             flow_nxt = flow_on;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flow_on  <= 1'b1;
      rts_n    <= 1'b1;
      ctl_pend <= 1'b0;
      ctl_char <= XON_CODE;
    end else begin
      flow_on <= flow_nxt;
      rts_n   <= !(hw_mode && flow_nxt);
      if (!sw_mode) begin
        ctl_pend <= 1'b0;
      end else if (go_off || go_on) begin
        ctl_pend <= 1'b1;
        ctl_char <= go_off ? XOFF_CODE : XON_CODE;
      end else if (ctl_taken) begin
        ctl_pend <= 1'b0;
      end
    end
  end

  AST_RTS_HIGH_MARK: assert property (@(posedge clk) disable iff (rst)
    (hw_mode && fill >= HW_V) |=> rts_n)
    else $error("request not released at high mark"); // R5
  AST_RTS_LOW_MARK: assert property (@(posedge clk) disable iff (rst)
    (hw_mode && fill <= RES_V) |=> !rts_n)
    else $error("request not asserted at low mark"); // R5
endmodule

// File: rtl/flowctl_txsel.sv
module flowctl_txsel import flowctl_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  tx_busy,
  input  logic  ctl_pend,
  input  byte_t ctl_char,
  input  logic  ctl_ok,
  input  logic  data_avail,
  input  byte_t data_byte,
  input  logic  data_ok,
  output logic  ctl_taken,
  output logic  data_pop,
  output logic  tx_start,
  output byte_t tx_byte
);
  logic can_go;

  always_comb begin
    can_go    = !tx_busy && !tx_start;
    ctl_taken = can_go && ctl_pend && ctl_ok;
    data_pop  = can_go && !ctl_taken && data_avail && data_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_start <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_start <= ctl_taken || data_pop;
      if (ctl_taken)     tx_byte <= ctl_char;
      else if (data_pop) tx_byte <= data_byte;
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start)
    else $error("start strobe longer than one cycle"); // R7
  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !$past(tx_busy))
    else $error("start issued while engine busy"); // R7
endmodule

// File: rtl/flowctl_unit.sv
module flowctl_unit import flowctl_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int RTS_HI = 5,
  parameter int SW_HI = 2,
  parameter int RESUME_LVL = 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_rts_mode,
  input  logic              cfg_cts_mode,
  input  logic              cfg_swflow,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rd_en,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CW-1:0]     rx_count,
  output logic              rx_overrun,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              tx_overrun,
  input  logic              tx_busy,
  output logic              tx_start,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              cts_n,
  output logic              rts_n
);
  logic          sw_active, rx_take, rx_ctl, rx_push, tx_allow, data_ok;
  logic          ctl_pend, ctl_taken, data_pop;
  byte_t         ctl_char, tx_head;
  logic [CW-1:0] tx_fill;

  always_comb begin
    sw_active = cfg_swflow && !cfg_rts_mode;
    rx_take   = rx_valid && !cfg_cts_mode;
    rx_ctl    = sw_active && (rx_data == XON_CODE || rx_data == XOFF_CODE);
    rx_push   = rx_take && !rx_ctl;
    data_ok   = !cfg_rts_mode && (!sw_active || tx_allow) &&
                (!cfg_cts_mode || !cts_n);
  end

  // remote pause/resume gate on local transmission
  always_ff @(posedge clk) begin
    if (rst)                                       tx_allow <= 1'b1;
    else if (rx_take && rx_ctl && rx_data == XON_CODE)  tx_allow <= 1'b1;
    else if (rx_take && rx_ctl && rx_data == XOFF_CODE) tx_allow <= 1'b0;
  end

  flowctl_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .wr_en(rx_push), .wr_data(rx_data),
    .rd_en(rd_en), .rd_data(rd_data), .count(rx_count), .overrun(rx_overrun)
  );

  flowctl_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(data_pop), .rd_data(tx_head), .count(tx_fill), .overrun(tx_overrun)
  );

  flowctl_throttle #(.CW(CW), .RTS_HI(RTS_HI), .SW_HI(SW_HI),
                     .RESUME_LVL(RESUME_LVL)) u_thr (
    .clk(clk), .rst(rst), .hw_mode(cfg_rts_mode), .sw_mode(sw_active),
    .fill(rx_count), .ctl_taken(ctl_taken), .rts_n(rts_n),
    .ctl_pend(ctl_pend), .ctl_char(ctl_char)
  );

  flowctl_txsel u_sel (
    .clk(clk), .rst(rst), .tx_busy(tx_busy), .ctl_pend(ctl_pend),
    .ctl_char(ctl_char), .ctl_ok(sw_active), .data_avail(tx_fill != '0),
    .data_byte(tx_head), .data_ok(data_ok), .ctl_taken(ctl_taken),
    .data_pop(data_pop), .tx_start(tx_start), .tx_byte(tx_byte)
  );

  AST_RTS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !cfg_rts_mode |=> rts_n)
    else $error("request line driven outside request mode"); // R5
  AST_RTS_NO_TX: assert property (@(posedge clk) disable iff (rst)
    cfg_rts_mode |=> !tx_start)
    else $error("byte started in request mode"); // R9
  AST_CTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cfg_cts_mode && cts_n && !sw_active) |=> !tx_start)
    else $error("byte started without clear"); // R8
  AST_CTS_NO_RX: assert property (@(posedge clk) disable iff (rst)
    (cfg_cts_mode && !rd_en) |=> $stable(rx_count))
    else $error("byte received in clear mode"); // R8
endmodule

// File: tb/tb_flowctl_unit.sv
`timescale 1ns/1ps
module tb_flowctl_unit;
  localparam int DEPTH = 8;
  localparam int BUSY_LEN = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rts_mode = 0, cfg_cts_mode = 0, cfg_swflow = 0;
  logic rx_valid = 0, rd_en = 0, wr_en = 0, cts_n = 1;
  logic [7:0] rx_data = 0, wr_data = 0;
  logic [7:0] rd_data, tx_byte;
  logic [3:0] rx_count;
  logic rx_overrun, tx_overrun, tx_start, rts_n, tx_busy;
  logic busy_q = 0, hold_busy = 0;

  always #2 clk = ~clk;
  assign tx_busy = busy_q || hold_busy;

  flowctl_unit dut (
    .clk(clk), .rst(rst), .cfg_rts_mode(cfg_rts_mode), .cfg_cts_mode(cfg_cts_mode),
    .cfg_swflow(cfg_swflow), .rx_valid(rx_valid), .rx_data(rx_data), .rd_en(rd_en),
    .rd_data(rd_data), .rx_count(rx_count), .rx_overrun(rx_overrun), .wr_en(wr_en),
    .wr_data(wr_data), .tx_overrun(tx_overrun), .tx_busy(tx_busy), .tx_start(tx_start),
    .tx_byte(tx_byte), .cts_n(cts_n), .rts_n(rts_n)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input int act, input int exp, input string tag);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  byte unsigned rxq[$], txq[$];
  bit m_ready = 0, m_ovr_rx, m_ovr_tx, m_allow, m_flow, m_rts_n, m_pend, m_start;
  byte unsigned m_pch, m_byte;

  always @(posedge clk) begin
    int rsz, tsz, hi;
    bit sw, act, can, nstart, took, off, on;
    if (rst) begin
      rxq.delete(); txq.delete();
      m_ready = 1; m_ovr_rx = 0; m_ovr_tx = 0; m_allow = 1; m_flow = 1;
      m_rts_n = 1; m_pend = 0; m_start = 0; m_pch = 8'h11; m_byte = 0;
    end else begin
      rsz = rxq.size(); tsz = txq.size();
      sw = cfg_swflow && !cfg_rts_mode;
      act = cfg_rts_mode || sw;
      can = !tx_busy && !m_start;
      nstart = 0; took = 0;
      if (can && m_pend && sw) begin
        nstart = 1; took = 1; m_byte = m_pch;
      end else if (can && tsz > 0 && !cfg_rts_mode && (!sw || m_allow) &&
                   (!cfg_cts_mode || !cts_n)) begin
        nstart = 1; m_byte = txq.pop_front();
      end
      if (wr_en) begin
        if (tsz == DEPTH) m_ovr_tx = 1; else txq.push_back(wr_data);
      end
      if (rd_en && rsz > 0) void'(rxq.pop_front());
      if (rx_valid && !cfg_cts_mode) begin
        if (sw && rx_data == 8'h11) m_allow = 1;
        else if (sw && rx_data == 8'h13) m_allow = 0;
        else if (rsz == DEPTH) m_ovr_rx = 1;
        else rxq.push_back(rx_data);
      end
      hi = cfg_rts_mode ? 5 : 2;
      off = act && m_flow && rsz >= hi;
      on = act && !m_flow && rsz <= 1;
      if (!sw) m_pend = 0;
      else if (off || on) begin m_pend = 1; m_pch = off ? 8'h13 : 8'h11; end
      else if (took) m_pend = 0;
      if (!act) m_flow = 1; else if (off) m_flow = 0; else if (on) m_flow = 1;
      m_rts_n = !(cfg_rts_mode && m_flow);
      m_start = nstart;
    end
  end

  // per-cycle comparison, bit-engine model and start monitor
  int busy_cnt = 0, n_starts = 0, n_xon = 0, n_xoff = 0;
  bit cap_arm = 0;
  int cap_byte = -1;

  always @(negedge clk) begin
    if (m_ready && !rst && !finished) begin
      chk(rx_count, rxq.size(), "R2 fill level");
      chk(rx_overrun, m_ovr_rx, "R2 receive overrun");
      chk(tx_overrun, m_ovr_tx, "R3 transmit overrun");
      chk(rts_n, m_rts_n, "R5 request line");
      chk(tx_start, m_start, "R7 start strobe");
      if (m_start) chk(tx_byte, m_byte, "R6 started byte");
      if (rxq.size() > 0) chk(rd_data, rxq[0], "R2 head byte");
    end
    if (tx_start) begin
      n_starts++;
      if (tx_byte == 8'h13) n_xoff++;
      if (tx_byte == 8'h11) n_xon++;
      if (cap_arm) begin cap_byte = tx_byte; cap_arm = 0; end
      busy_cnt = BUSY_LEN;
    end else if (busy_cnt > 0) busy_cnt--;
    busy_q = (busy_cnt != 0);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic push_rx(input logic [7:0] b);
    rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask
  task automatic pop_rx();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask
  task automatic put_tx(input logic [7:0] b);
    wr_en = 1; wr_data = b; @(negedge clk); wr_en = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    int s0;
    idle(3);
    rst = 0;
    // R1 reset state
    chk(rx_count, 0, "R1 fill"); chk(rts_n, 1, "R1 rts_n");
    chk(tx_start, 0, "R1 start"); chk(rx_overrun, 0, "R1 rx overrun");
    chk(tx_overrun, 0, "R1 tx overrun");

    // R3 plain transmit in order
    for (int i = 0; i < 3; i++) put_tx(8'hA0 + 8'(i));
    idle(30);
    chk(n_starts, 3, "R3 bytes sent");

    // R2 receive overflow and order
    for (int i = 0; i < 9; i++) push_rx(8'h30 + 8'(i));
    idle(2);
    chk(rx_count, 8, "R2 full level"); chk(rx_overrun, 1, "R2 overrun set");
    for (int i = 0; i < 8; i++) begin
      chk(rd_data, 8'h30 + i, "R2 order"); pop_rx();
    end
    pop_rx();
    chk(rx_count, 0, "R2 empty read ignored");

    // R5 / R9 request mode
    cfg_rts_mode = 1; idle(2);
    chk(rts_n, 0, "R5 asserted when empty");
    s0 = n_starts;
    for (int i = 0; i < 9; i++) put_tx(8'h50 + 8'(i));
    idle(20);
    chk(tx_overrun, 1, "R3 overrun set"); chk(n_starts, s0, "R9 no transmit");
    for (int i = 0; i < 4; i++) push_rx(8'h60 + 8'(i));
    idle(2); chk(rts_n, 0, "R5 below high mark");
    push_rx(8'h64); idle(2); chk(rts_n, 1, "R5 released at 5");
    repeat (3) pop_rx(); idle(2); chk(rts_n, 1, "R5 held at 2");
    pop_rx(); idle(2); chk(rts_n, 0, "R5 resumed at 1");
    pop_rx();
    cfg_rts_mode = 0; idle(80);
    chk(n_starts, s0 + 8, "R3 queue drained");
    chk(rts_n, 1, "R5 released outside mode");

    // R4 / R6 / R7 software mode
    cfg_swflow = 1; idle(2);
    push_rx(8'h13); idle(2); chk(rx_count, 0, "R4 pause not stored");
    s0 = n_starts;
    put_tx(8'h71); put_tx(8'h72); idle(20);
    chk(n_starts, s0, "R4 paused");
    push_rx(8'h11); idle(20);
    chk(n_starts, s0 + 2, "R4 resumed"); chk(rx_count, 0, "R4 resume not stored");
    push_rx(8'h41); push_rx(8'h42); idle(15);
    chk(n_xoff, 1, "R6 pause sent at 2");
    pop_rx(); idle(15);
    chk(n_xon, 1, "R6 resume sent at 1");
    hold_busy = 1; idle(2);
    s0 = n_starts;
    for (int i = 0; i < 3; i++) put_tx(8'h80 + 8'(i));
    push_rx(8'h43); idle(10);
    chk(n_starts, s0, "R7 waits while busy");
    cap_arm = 1; idle(1);
    hold_busy = 0; idle(40);
    chk(cap_byte, 8'h13, "R7 code before data");
    chk(n_starts, s0 + 4, "R7 all sent");
    pop_rx(); pop_rx(); idle(15);
    chk(n_xon, 2, "R6 one resume per crossing");
    chk(n_xoff, 2, "R6 one pause per crossing");
    cfg_swflow = 0; idle(2);

    // R8 clear mode
    cfg_cts_mode = 1; cts_n = 1; idle(2);
    push_rx(8'h22); push_rx(8'h23); idle(2);
    chk(rx_count, 0, "R8 receive ignored");
    s0 = n_starts;
    put_tx(8'h91); put_tx(8'h92); idle(20);
    chk(n_starts, s0, "R8 held without clear");
    cts_n = 0; idle(20);
    chk(n_starts, s0 + 2, "R8 sent with clear");
    cfg_cts_mode = 0; cts_n = 1; idle(2);

    // R9 request mode wins over software mode
    cfg_rts_mode = 1; cfg_swflow = 1; idle(2);
    push_rx(8'h11); idle(2);
    chk(rx_count, 1, "R9 code stored"); chk(rd_data, 8'h11, "R9 code value");
    pop_rx(); cfg_rts_mode = 0; cfg_swflow = 0; idle(4);

    // mixed random traffic against the model
    for (int c = 0; c < 3000; c++) begin
      if (c % 250 == 0) begin
        cfg_rts_mode = ($urandom % 4 == 0);
        cfg_cts_mode = ($urandom % 4 == 0);
        cfg_swflow   = ($urandom % 2 == 0);
      end
      cts_n    = ($urandom % 3 == 0);
      rx_valid = ($urandom % 3 == 0);
      rx_data  = ($urandom % 6 == 0) ? (($urandom % 2) ? 8'h11 : 8'h13) : 8'($urandom);
      rd_en    = ($urandom % 4 == 0);
      wr_en    = ($urandom % 4 == 0);
      wr_data  = 8'($urandom);
      @(negedge clk);
    end
    rx_valid = 0; rd_en = 0; wr_en = 0;
    idle(5);
    finish_run();
  end
endmodule